// File: doc/BRIEF.md
# Banked Extended-RAM Access Port

This block is a byte-wide register file that gives a host bus access to a large battery-backed RAM. The RAM has no direct address range. The host loads a RAM pointer through two pointer registers, then moves data through one data-port register. When burst mode is on, every access to the data port also advances the pointer, so a long block can be streamed without rewriting the pointer.

The pointer, the data port, the burst-enable control and a small read-only identity area can be reached only while a bank-select bit is set. With that bit clear, the same upper address window is ordinary general-purpose RAM. A further general-purpose RAM area sits below it and does not depend on the bank.

The host bus is synchronous. Each cycle carries at most one read or one write. Read data appears on the cycle after the read strobe.

Top module: `xram_port`

## Requirements
- R1: After reset the bank bit, the burst bit and the RAM pointer are all 0, and `rdata` is 0.
- R2: A read strobed in one cycle returns its data on `rdata` in the next cycle. In any cycle after a cycle without a read, `rdata` is 0.
- R3: Bit 4 of the byte at host address 0x0A is the bank bit (1 selects bank 1). Reading 0x0A returns the bank bit in bit 4 and 0 in every other bit.
- R4: In bank 1, address 0x50 reads and writes pointer bits 7:0. Address 0x51 reads and writes the pointer bits above bit 7. Written bits beyond the RAM size are dropped, and they read back as 0.
- R5: In bank 1, address 0x53 is the data port. A write stores the byte at the pointed RAM location, and a read returns the byte held there.
- R6: While the burst bit is 0, an access to the data port leaves the pointer unchanged.
- R7: In bank 1, bit 5 of address 0x4A is the burst bit, and it reads back in bit 5 with all other bits 0. While the burst bit is set, each data-port read or write raises the pointer by one. The pointer wraps to 0 after RAM_BYTES-1.
- R8: In bank 1, addresses 0x40 to 0x47 are read-only identity bytes, and writes to them change nothing:
  - offset 0 holds MODEL_ID;
  - offset k, for k from 1 to 6, holds SERIAL_SEED XOR ((37*k) mod 256);
  - offset 7 holds the XOR of offsets 0 to 6.
- R9: In bank 0, addresses 0x40 to 0x7F are 64 bytes of read/write RAM. Writes there never reach the bank-1 registers and never move the pointer.
- R10: Addresses 0x0E to 0x3F are 50 bytes of read/write RAM. They are reachable in both banks and hold the same contents in each.
- R11: The following addresses read as 0, and writes to them are ignored:
  - 0x00 to 0x09 and 0x0B to 0x0D;
  - every bank-1 address from 0x48 to 0x7F except 0x4A, 0x50, 0x51 and 0x53.
- R12: A pointer write takes effect for the very next data-port access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | HOST_AW | Host register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, one cycle after `rd_en` |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high in the same cycle. They also assume that `addr` stays within the host window of 2^HOST_AW bytes. The pointer-step properties rely on this, because only one access can touch the pointer in a cycle. The bench drives all traffic through read and write tasks. Each task raises exactly one strobe for exactly one cycle and leaves the bus idle between accesses, so every stimulus stays inside these assumptions. The full-RAM sweep uses only burst writes and burst reads through the data port.

// File: rtl/xram_pkg.sv
package xram_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_BANKREG,
    SEL_SCRATCH,
    SEL_LOWRAM,
    SEL_ID,
    SEL_EXTCTL,
    SEL_PLO,
    SEL_PHI,
    SEL_PORT
  } sel_e;

  localparam int A_BANKREG  = 'h0A;
  localparam int A_SCR_LO   = 'h0E;
  localparam int A_SCR_HI   = 'h3F;
  localparam int A_WIN_LO   = 'h40;
  localparam int A_ID_HI    = 'h47;
  localparam int A_EXTCTL   = 'h4A;
  localparam int A_PLO      = 'h50;
  localparam int A_PHI      = 'h51;
  localparam int A_PORT     = 'h53;
  localparam int BANK_BIT   = 4;
  localparam int BURST_BIT  = 5;

  // Identity byte k of the read-only area in bank 1.
  function automatic logic [7:0] id_byte(input logic [2:0] k,
                                         input logic [7:0] model,
                                         input logic [7:0] seed);
    logic [7:0] acc;
    if (k == 3'd0) return model;
    if (k != 3'd7) return seed ^ (8'(k) * 8'h25);
    acc = model;
    for (int j = 1; j < 7; j++) acc ^= seed ^ (8'(j) * 8'h25);
    return acc;
  endfunction

endpackage

// File: rtl/xram_decode.sv
module xram_decode
  import xram_pkg::*;
#(
  parameter int HOST_AW = 7
) (
  input  logic [HOST_AW-1:0] addr,
  input  logic               bank,
  output sel_e               sel,
  output logic [5:0]         scr_idx,
  output logic [5:0]         low_idx,
  output logic [2:0]         id_idx
);
  int a;

  always_comb begin
    a       = int'(addr);
    scr_idx = 6'(a - A_SCR_LO);
    low_idx = 6'(a - A_WIN_LO);
    id_idx  = 3'(a - A_WIN_LO);
    sel     = SEL_NONE;
    if (a == A_BANKREG) begin
      sel = SEL_BANKREG;
    end else if (a >= A_SCR_LO && a <= A_SCR_HI) begin
      sel = SEL_SCRATCH;
    end else if (a >= A_WIN_LO && a < A_WIN_LO + 64) begin
      if (!bank) sel = SEL_LOWRAM;
      else if (a <= A_ID_HI) sel = SEL_ID;
      else if (a == A_EXTCTL) sel = SEL_EXTCTL;
      else if (a == A_PLO) sel = SEL_PLO;
      else if (a == A_PHI) sel = SEL_PHI;
      else if (a == A_PORT) sel = SEL_PORT;
      else sel = SEL_NONE;
    end
  end
endmodule

// File: rtl/xram_pointer.sv
module xram_pointer #(
  parameter int PTR_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_lo,
  input  logic             ld_hi,
  input  logic             step,
  input  logic [7:0]       wdata,
  output logic [PTR_W-1:0] ptr
);
  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ld_lo) begin
      ptr[7:0] <= wdata;
    end else if (ld_hi) begin
      ptr[PTR_W-1:8] <= wdata[PTR_W-9:0];
    end else if (step) begin
      ptr <= bump(ptr);
    end
  end
endmodule

// File: rtl/xram_bytes.sv
module xram_bytes #(
  parameter int DEPTH = 64,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    wdata,
  output logic [7:0]    q
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wdata;
  end

  assign q = cells[idx];
endmodule

// File: rtl/xram_port.sv
module xram_port
  import xram_pkg::*;
#(
  parameter int         HOST_AW     = 7,
  parameter int         RAM_BYTES   = 2048,
  parameter logic [7:0] MODEL_ID    = 8'h5A,
  parameter logic [7:0] SERIAL_SEED = 8'hC3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] addr,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata
);
  localparam int PTR_W   = $clog2(RAM_BYTES);
  localparam int SCR_N   = A_SCR_HI - A_SCR_LO + 1;
  localparam int LOW_N   = 64;
  localparam int SCR_IW  = $clog2(SCR_N);

  sel_e             sel;
  logic [5:0]       scr_idx, low_idx;
  logic [2:0]       id_idx;
  logic             bank_q, burst_q;
  logic [PTR_W-1:0] xptr;
  logic [7:0]       scr_q, low_q, ext_q, rd_val;

  // Named events used by the checker.
  logic port_rd, port_wr, port_acc, ptr_step;
  assign port_rd  = rd_en && (sel == SEL_PORT);
  assign port_wr  = wr_en && (sel == SEL_PORT);
  assign port_acc = port_rd || port_wr;
  assign ptr_step = port_acc && burst_q;

  xram_decode #(.HOST_AW(HOST_AW)) u_dec (
    .addr(addr), .bank(bank_q), .sel(sel),
    .scr_idx(scr_idx), .low_idx(low_idx), .id_idx(id_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= 1'b0;
      burst_q <= 1'b0;
    end else if (wr_en) begin
      if (sel == SEL_BANKREG) bank_q  <= wdata[BANK_BIT];
      if (sel == SEL_EXTCTL)  burst_q <= wdata[BURST_BIT];
    end
  end

  xram_pointer #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .ld_lo(wr_en && sel == SEL_PLO),
    .ld_hi(wr_en && sel == SEL_PHI),
    .step(ptr_step), .wdata(wdata), .ptr(xptr)
  );

  xram_bytes #(.DEPTH(SCR_N)) u_scr (
    .clk(clk), .we(wr_en && sel == SEL_SCRATCH),
    .idx(scr_idx[SCR_IW-1:0]), .wdata(wdata), .q(scr_q)
  );

  xram_bytes #(.DEPTH(LOW_N)) u_low (
    .clk(clk), .we(wr_en && sel == SEL_LOWRAM),
    .idx(low_idx), .wdata(wdata), .q(low_q)
  );

  xram_bytes #(.DEPTH(RAM_BYTES)) u_ext (
    .clk(clk), .we(port_wr), .idx(xptr), .wdata(wdata), .q(ext_q)
  );

  always_comb begin
    rd_val = 8'h00;
    case (sel)
      SEL_BANKREG: rd_val[BANK_BIT]  = bank_q;
      SEL_EXTCTL:  rd_val[BURST_BIT] = burst_q;
      SEL_SCRATCH: rd_val = scr_q;
      SEL_LOWRAM:  rd_val = low_q;
      SEL_ID:      rd_val = id_byte(id_idx, MODEL_ID, SERIAL_SEED);
      SEL_PLO:     rd_val = xptr[7:0];
      SEL_PHI:     rd_val = {{(16-PTR_W){1'b0}}, xptr[PTR_W-1:8]};
      SEL_PORT:    rd_val = ext_q;
      default:     rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= 8'h00;
    else        rdata <= rd_en ? rd_val : 8'h00;
  end
endmodule

// File: rtl/xram_port_chk.sv
module xram_port_chk #(
  parameter int         HOST_AW  = 7,
  parameter int         PTR_W    = 11,
  parameter logic [7:0] MODEL_ID = 8'h5A
) (
  input logic               clk,
  input logic               rst_n,
  input logic [HOST_AW-1:0] addr,
  input logic               wr_en,
  input logic               rd_en,
  input logic [7:0]         rdata,
  input logic               bank_q,
  input logic               burst_q,
  input logic               port_acc,
  input logic [PTR_W-1:0]   xptr
);
  a_r7_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (port_acc && burst_q) |=> (xptr == PTR_W'($past(xptr) + 1'b1)));

  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (port_acc && !burst_q) |=> $stable(xptr));

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == 8'h00));

  a_r9_bank0_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_q && (wr_en || rd_en)) |=> $stable(xptr));

  a_r8_model_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bank_q && int'(addr) == 'h40) |=> (rdata == MODEL_ID));

  a_r3_bank_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(addr) == 'h0A) |=> (rdata == {3'b000, $past(bank_q), 4'b0000}));

  a_r4_hi_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bank_q && int'(addr) == 'h51) |=> (rdata[7:PTR_W-8] == '0));
endmodule

bind xram_port xram_port_chk #(
  .HOST_AW(HOST_AW), .PTR_W(PTR_W), .MODEL_ID(MODEL_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .bank_q(bank_q), .burst_q(burst_q),
  .port_acc(port_acc), .xptr(xptr)
);

// File: tb/xram_port_bench.sv
module xram_port_bench;
  localparam int CLK_NS = 10;
  localparam int AW = 7;
  localparam int NBYTES = 2048;
  localparam int PW = 11;
  localparam logic [7:0] MODEL = 8'h5A;
  localparam logic [7:0] SEED = 8'hC3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  int total = 0, bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  xram_port #(.HOST_AW(AW), .RAM_BYTES(NBYTES), .MODEL_ID(MODEL), .SERIAL_SEED(SEED))
    u_xram_port (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                 .rd_en(rd_en), .wdata(wdata), .rdata(rdata));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = AW'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rdchk(input string req, input int a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic setptr(input int p);
    wr('h50, 8'(p));
    wr('h51, 8'(p >> 8));
  endtask

  function automatic logic [7:0] idv(input int k);
    logic [7:0] x;
    if (k == 0) return MODEL;
    if (k < 7) return SEED ^ 8'((k * 37) % 256);
    x = MODEL;
    for (int j = 1; j < 7; j++) x = x ^ SEED ^ 8'((j * 37) % 256);
    return x;
  endfunction

  initial begin
    #(CLK_NS * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata after reset", rdata, 8'h00);
    rst_n = 1'b1;
    rdchk("R1 bank bit", 'h0A, 8'h00);
    wr('h0A, 8'h10);
    rdchk("R1 ptr lo", 'h50, 8'h00);
    rdchk("R1 ptr hi", 'h51, 8'h00);
    rdchk("R1 burst bit", 'h4A, 8'h00);

    // R3 bank bit readback
    wr('h0A, 8'hFF);
    rdchk("R3 bank set", 'h0A, 8'h10);
    wr('h0A, 8'hEF);
    rdchk("R3 bank clear", 'h0A, 8'h00);

    // R2 idle cycle gives zero
    rdchk("R2 read returns", 'h0A, 8'h00);
    @(negedge clk);
    chk("R2 idle zero", rdata, 8'h00);

    // R10 scratch shared by both banks
    for (int a = 'h0E; a <= 'h3F; a++) wr(a, 8'((a * 7 + 3) % 256));
    wr('h0A, 8'h10);
    for (int a = 'h0E; a <= 'h3F; a++) rdchk("R10 scratch", a, 8'((a * 7 + 3) % 256));
    wr('h0A, 8'h00);

    // R9 bank-0 window RAM
    for (int a = 'h40; a <= 'h7F; a++) wr(a, 8'(a) ^ 8'hA5);
    for (int a = 'h40; a <= 'h7F; a++) rdchk("R9 low ram", a, 8'(a) ^ 8'hA5);
    wr('h0A, 8'h10);
    rdchk("R9 ptr untouched lo", 'h50, 8'h00);
    rdchk("R9 ptr untouched hi", 'h51, 8'h00);
    rdchk("R9 burst untouched", 'h4A, 8'h00);

    // R8 identity bytes, read-only
    for (int k = 0; k < 8; k++) rdchk("R8 id byte", 'h40 + k, idv(k));
    for (int k = 0; k < 8; k++) wr('h40 + k, 8'hFF);
    for (int k = 0; k < 8; k++) rdchk("R8 id after write", 'h40 + k, idv(k));

    // R11 unmapped
    wr('h52, 8'h77);
    wr('h05, 8'h77);
    rdchk("R11 addr 00", 'h00, 8'h00);
    rdchk("R11 addr 05", 'h05, 8'h00);
    rdchk("R11 addr 0B", 'h0B, 8'h00);
    rdchk("R11 addr 4B", 'h4B, 8'h00);
    rdchk("R11 addr 52", 'h52, 8'h00);
    rdchk("R11 addr 7F", 'h7F, 8'h00);

    // R4 pointer registers
    wr('h50, 8'h34);
    wr('h51, 8'hFF);
    rdchk("R4 ptr lo", 'h50, 8'h34);
    rdchk("R4 ptr hi masked", 'h51, 8'h07);

    // R5 / R6 burst off
    wr('h53, 8'hAB);
    rdchk("R6 ptr held after write", 'h50, 8'h34);
    rdchk("R5 port read", 'h53, 8'hAB);
    rdchk("R6 ptr held after read lo", 'h50, 8'h34);
    rdchk("R6 ptr held after read hi", 'h51, 8'h07);

    // R12 pointer writes apply at once
    setptr('h100); wr('h53, 8'h11);
    setptr('h101); wr('h53, 8'h22);
    setptr('h100); rdchk("R12 first", 'h53, 8'h11);
    setptr('h101); rdchk("R12 second", 'h53, 8'h22);
    setptr('h734); rdchk("R5 earlier byte", 'h53, 8'hAB);

    // R7 burst with wrap
    wr('h4A, 8'hFF);
    rdchk("R7 burst readback", 'h4A, 8'h20);
    setptr(NBYTES - 4);
    for (int k = 0; k < 6; k++) wr('h53, 8'(8'h60 + k));
    rdchk("R7 wrap lo", 'h50, 8'h02);
    rdchk("R7 wrap hi", 'h51, 8'h00);
    setptr(NBYTES - 4);
    for (int k = 0; k < 6; k++) rdchk("R7 burst read", 'h53, 8'(8'h60 + k));
    rdchk("R7 wrap after read", 'h50, 8'h02);

    // R7 full sweep of the RAM through burst access
    setptr(0);
    for (int i = 0; i < NBYTES; i++) wr('h53, 8'((i * 13 + (i >> 8)) % 256));
    rdchk("R7 sweep wrap lo", 'h50, 8'h00);
    rdchk("R7 sweep wrap hi", 'h51, 8'h00);
    for (int i = 0; i < NBYTES; i++) rdchk("R5 sweep", 'h53, 8'((i * 13 + (i >> 8)) % 256));

    // R9 bank-0 data unaffected by bank-1 traffic
    wr('h0A, 8'h00);
    rdchk("R9 low ram kept", 'h50, 8'h50 ^ 8'hA5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule